// File: doc/BRIEF.md
# SATA Port Multiplier Frame Router

This block sits between one upstream host link and four downstream device links of a port multiplier. The streams on all sides are word-wide frames with start-of-frame, end-of-frame, valid and ready. Every frame carries a 4-bit port number in bits [11:8] of its first word. Host frames are steered by that number. Values 0 to 3 pick a device link. Value 15 picks a local control endpoint that answers register reads. Values 4 to 14 are swallowed and raise a sticky error flag.

In the other direction, the four device links and the control endpoint compete for the single host link. A round-robin arbiter grants whole frames. As a frame passes, the arbiter writes the number of its source port into the port field of the first word. Both paths are flow controlled end to end. A stall on any link holds the current word in place, and no word is lost or repeated.

The steering machine `pmr_down_steer` has four states. DS_HDR waits for a header. From DS_HDR it moves on an accepted multi-word header to DS_DEV (device port), DS_CTL (port 15) or DS_DROP (port 4 to 14). Each of these returns to DS_HDR when an end-of-frame word is accepted. A single-word frame leaves it in DS_HDR.

The control endpoint `pmr_ctrl_ep` has four states:
- CE_IDLE takes a request header. It goes to CE_RHDR if the request is a single word, otherwise to CE_TAKE.
- CE_TAKE absorbs the rest of the request and goes to CE_RHDR on its last word.
- CE_RHDR sends the response header and goes to CE_RDATA when that word is accepted.
- CE_RDATA sends the value word and goes back to CE_IDLE when it is accepted.

The arbiter `pmr_up_arb` has three states. UA_IDLE picks a winner and goes to UA_HDR. UA_HDR sends the rewritten header. It goes to UA_BODY, or straight back to UA_IDLE if the header is also the last word. UA_BODY returns to UA_IDLE on the last word.

Top module: `pm_frame_router`

## Requirements
- R1: While reset is asserted, host_tx_valid, every bit of dev_tx_valid, and bad_port_err are all 0.
- R2: A host frame whose first word has bits [11:8] in the range 0 to 3 appears on that device link with every word unchanged, including sof and eof, and in arrival order.
- R3: A host frame with port field 15 reaches no device link. It is answered upstream by exactly one two-word frame. The first word is the request's first word with port field 15. The second word is the value of the register named in bits [7:0] of the request header: 0 returns the device count (4), 1 returns the error flag in bit 0, and any other register returns 0.
- R4: A host frame with port field 4 to 14 is consumed and reaches no output. bad_port_err goes to 1 in the cycle after its header is accepted and stays at 1 until reset.
- R5: On the host link, the first word of each frame carries the source port number in bits [11:8]: 0 to 3 for devices and 15 for the control endpoint. All other bits and all later words are unchanged.
- R6: Once a frame has started on the host link, only words of that frame follow until its eof word.
- R7: The upstream arbiter decides only between frames. It serves the first pending source after the last granted one in the cyclic order 0, 1, 2, 3, control. After reset, device 0 is served first.
- R8: When valid is high and ready is low on any output link, the next cycle shows the same word with valid still high. Throttling in any mix loses and duplicates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_rx_data | input | 32 | Word from the host |
| host_rx_sof | input | 1 | First word of a host frame |
| host_rx_eof | input | 1 | Last word of a host frame |
| host_rx_valid | input | 1 | Host word present |
| host_rx_ready | output | 1 | Router takes the host word |
| host_tx_data | output | 32 | Word to the host |
| host_tx_sof | output | 1 | First word of an upstream frame |
| host_tx_eof | output | 1 | Last word of an upstream frame |
| host_tx_valid | output | 1 | Upstream word present |
| host_tx_ready | input | 1 | Host takes the word |
| dev_tx_data | output | 128 | Word to each device, 32 bits per port, port 0 lowest |
| dev_tx_sof | output | 4 | First word, per device |
| dev_tx_eof | output | 4 | Last word, per device |
| dev_tx_valid | output | 4 | Word present, per device |
| dev_tx_ready | input | 4 | Device takes the word |
| dev_rx_data | input | 128 | Word from each device, 32 bits per port |
| dev_rx_sof | input | 4 | First word, per device |
| dev_rx_eof | input | 4 | Last word, per device |
| dev_rx_valid | input | 4 | Device word present |
| dev_rx_ready | output | 4 | Router takes the device word |
| bad_port_err | output | 1 | Sticky flag for a host frame with port 4 to 14 |

## Verification
A register response from the control endpoint and device frames can request the single host link in the same cycle. Meanwhile the steering machine keeps moving further host frames to the device links. To provoke this, the bench issues register reads interleaved with device-bound host frames while all four device links hold queued upstream frames, with both ready sides randomly throttled. Each upstream frame is judged against a per-source queue selected by its rewritten port field, so an interleaved, lost or misrouted word shows up as a mismatch. Directed arbitration rounds with a known last grant check the exact serving order.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    // host-to-device steering machine
    typedef enum logic [1:0] {
        DS_HDR,
        DS_DEV,
        DS_CTL,
        DS_DROP
    } steer_state_e;

    // local register responder
    typedef enum logic [1:0] {
        CE_IDLE,
        CE_TAKE,
        CE_RHDR,
        CE_RDATA
    } ctrl_state_e;

    // device-to-host arbiter
    typedef enum logic [1:0] {
        UA_IDLE,
        UA_HDR,
        UA_BODY
    } arb_state_e;

endpackage

// File: rtl/pmr_down_steer.sv
module pmr_down_steer
    import pmr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DW      = 32,
    parameter int PF_LSB  = 8,
    parameter int PF_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DW-1:0]      in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic               in_valid,
    output logic               in_ready,
    output logic [NUM_DEV-1:0] dev_valid,
    input  logic [NUM_DEV-1:0] dev_ready,
    output logic               ctl_valid,
    input  logic               ctl_ready,
    output logic               bad_err
);

    localparam int SELW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam logic [PF_W-1:0] CTL_ID = '1;

    steer_state_e       state_q, state_d;
    logic [SELW-1:0]    sel_q, sel_d;
    logic [PF_W-1:0]    fld;
    logic [NUM_DEV-1:0] fld_dec;
    logic               is_dev, is_ctl, fire, bad_hdr;

    assign fld = in_data[PF_LSB +: PF_W];

    always_comb begin
        for (int i = 0; i < NUM_DEV; i++) begin
            fld_dec[i] = (fld == PF_W'(i));
        end
    end

    assign is_dev  = |fld_dec;
    assign is_ctl  = (fld == CTL_ID);
    assign fire    = in_valid & in_ready;
    assign bad_hdr = (state_q == DS_HDR) & in_valid & in_sof & ~is_dev & ~is_ctl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_HDR;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            DS_HDR: begin
                if (fire && in_sof && is_dev) begin
                    sel_d = fld[SELW-1:0];
                end
                if (fire && in_sof && !in_eof) begin
                    if (is_dev) begin
                        state_d = DS_DEV;
                    end else if (is_ctl) begin
                        state_d = DS_CTL;
                    end else begin
                        state_d = DS_DROP;
                    end
                end
            end
            DS_DEV, DS_CTL, DS_DROP: begin
                if (fire && in_eof) begin
                    state_d = DS_HDR;
                end
            end
            default: state_d = DS_HDR;
        endcase
    end

    // outputs
    always_comb begin
        dev_valid = '0;
        ctl_valid = 1'b0;
        in_ready  = 1'b0;
        unique case (state_q)
            DS_HDR: begin
                if (!in_sof) begin
                    in_ready = 1'b1;
                end else if (is_dev) begin
                    dev_valid = fld_dec & {NUM_DEV{in_valid}};
                    in_ready  = |(fld_dec & dev_ready);
                end else if (is_ctl) begin
                    ctl_valid = in_valid;
                    in_ready  = ctl_ready;
                end else begin
                    in_ready = 1'b1;
                end
            end
            DS_DEV: begin
                for (int i = 0; i < NUM_DEV; i++) begin
                    if (sel_q == SELW'(i)) begin
                        dev_valid[i] = in_valid;
                        in_ready     = dev_ready[i];
                    end
                end
            end
            DS_CTL: begin
                ctl_valid = in_valid;
                in_ready  = ctl_ready;
            end
            DS_DROP: in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
    end

    // sticky bad-port flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_err <= 1'b0;
        end else if (bad_hdr) begin
            bad_err <= 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_DEV; g++) begin : g_hold
            assert_dev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                dev_valid[g] && !dev_ready[g] |=> dev_valid[g] && $stable(in_data));
        end
    endgenerate

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_err |=> bad_err);

    assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DS_DROP |-> dev_valid == '0 && !ctl_valid);

endmodule

// File: rtl/pmr_ctrl_ep.sv
module pmr_ctrl_ep
    import pmr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DW      = 32,
    parameter int PF_LSB  = 8,
    parameter int PF_W    = 4,
    parameter int RA_W    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rq_data,
    input  logic          rq_sof,
    input  logic          rq_eof,
    input  logic          rq_valid,
    output logic          rq_ready,
    input  logic          err_in,
    output logic [DW-1:0] rs_data,
    output logic          rs_sof,
    output logic          rs_eof,
    output logic          rs_valid,
    input  logic          rs_ready
);

    ctrl_state_e     state_q, state_d;
    logic [DW-1:0]   hdr_q, val_q, val_d, hdr_out;
    logic [RA_W-1:0] ra;
    logic            rq_fire, take_hdr, req_done;

    assign rq_fire  = rq_valid & rq_ready;
    assign take_hdr = (state_q == CE_IDLE) & rq_fire & rq_sof;
    assign req_done = (take_hdr & rq_eof) | ((state_q == CE_TAKE) & rq_fire & rq_eof);
    assign ra       = (state_q == CE_IDLE) ? rq_data[RA_W-1:0] : hdr_q[RA_W-1:0];
    assign hdr_out  = hdr_q | (DW'({PF_W{1'b1}}) << PF_LSB);

    // register decode
    always_comb begin
        val_d = '0;
        if (ra == RA_W'(0)) begin
            val_d = DW'(NUM_DEV);
        end else if (ra == RA_W'(1)) begin
            val_d = DW'(err_in);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CE_IDLE;
            hdr_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_hdr) begin
                hdr_q <= rq_data;
            end
            if (req_done) begin
                val_q <= val_d;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CE_IDLE:  if (take_hdr) state_d = rq_eof ? CE_RHDR : CE_TAKE;
            CE_TAKE:  if (rq_fire && rq_eof) state_d = CE_RHDR;
            CE_RHDR:  if (rs_ready) state_d = CE_RDATA;
            CE_RDATA: if (rs_ready) state_d = CE_IDLE;
            default:  state_d = CE_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rq_ready = 1'b0;
        rs_valid = 1'b0;
        rs_sof   = 1'b0;
        rs_eof   = 1'b0;
        rs_data  = val_q;
        unique case (state_q)
            CE_IDLE, CE_TAKE: rq_ready = 1'b1;
            CE_RHDR: begin
                rs_valid = 1'b1;
                rs_sof   = 1'b1;
                rs_data  = hdr_out;
            end
            CE_RDATA: begin
                rs_valid = 1'b1;
                rs_eof   = 1'b1;
            end
            default: rq_ready = 1'b0;
        endcase
    end

    assert_resp_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid && rs_sof && rs_ready |=> rs_valid && rs_eof && !rs_sof);

endmodule

// File: rtl/pmr_up_arb.sv
module pmr_up_arb
    import pmr_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DW      = 32,
    parameter int PF_LSB  = 8,
    parameter int PF_W    = 4,
    localparam int NSRC   = NUM_DEV + 1,
    localparam int SW     = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC*DW-1:0] src_data,
    input  logic [NSRC-1:0]    src_sof,
    input  logic [NSRC-1:0]    src_eof,
    input  logic [NSRC-1:0]    src_valid,
    output logic [NSRC-1:0]    src_ready,
    output logic [DW-1:0]      up_data,
    output logic               up_sof,
    output logic               up_eof,
    output logic               up_valid,
    input  logic               up_ready
);

    arb_state_e      state_q, state_d;
    logic [SW-1:0]   gnt_q, gnt_d, win;
    logic [NSRC-1:0] req;
    logic            found, up_fire;
    logic [DW-1:0]   g_data;
    logic            g_sof, g_eof, g_valid;
    logic [PF_W-1:0] g_id;

    assign req     = src_valid & src_sof;
    assign g_data  = src_data[gnt_q*DW +: DW];
    assign g_sof   = src_sof[gnt_q];
    assign g_eof   = src_eof[gnt_q];
    assign g_valid = src_valid[gnt_q];
    assign g_id    = (gnt_q == SW'(NUM_DEV)) ? {PF_W{1'b1}} : PF_W'(gnt_q);
    assign up_fire = up_valid & up_ready;

    // round-robin search starting after the last grant
    always_comb begin
        found = 1'b0;
        win   = gnt_q;
        for (int k = 1; k <= NSRC; k++) begin
            if (!found && req[(int'(gnt_q) + k) % NSRC]) begin
                found = 1'b1;
                win   = SW'((int'(gnt_q) + k) % NSRC);
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UA_IDLE;
            gnt_q   <= SW'(NSRC - 1);
        end else begin
            state_q <= state_d;
            gnt_q   <= gnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        gnt_d   = gnt_q;
        unique case (state_q)
            UA_IDLE: begin
                if (found) begin
                    state_d = UA_HDR;
                    gnt_d   = win;
                end
            end
            UA_HDR:  if (up_fire) state_d = g_eof ? UA_IDLE : UA_BODY;
            UA_BODY: if (up_fire && g_eof) state_d = UA_IDLE;
            default: state_d = UA_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        src_ready = '0;
        up_valid  = 1'b0;
        up_data   = g_data;
        up_sof    = g_sof;
        up_eof    = g_eof;
        unique case (state_q)
            UA_IDLE: src_ready = src_valid & ~src_sof;
            UA_HDR: begin
                up_valid                  = g_valid;
                up_data[PF_LSB +: PF_W]   = g_id;
                src_ready[gnt_q]          = up_ready;
            end
            UA_BODY: begin
                up_valid         = g_valid;
                src_ready[gnt_q] = up_ready;
            end
            default: up_valid = 1'b0;
        endcase
    end

    assert_up_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_ready |=> up_valid && $stable(up_data));

    assert_hdr_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_sof |->
            (up_data[PF_LSB +: PF_W] < NUM_DEV) || (up_data[PF_LSB +: PF_W] == {PF_W{1'b1}}));

    assert_grant_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != UA_IDLE && !(up_fire && up_eof) |=> $stable(gnt_q) && state_q != UA_IDLE);

endmodule

// File: rtl/pm_frame_router.sv
module pm_frame_router #(
    parameter int NUM_DEV = 4,
    parameter int DW      = 32,
    parameter int PF_LSB  = 8,
    parameter int PF_W    = 4,
    parameter int RA_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         host_rx_data,
    input  logic                  host_rx_sof,
    input  logic                  host_rx_eof,
    input  logic                  host_rx_valid,
    output logic                  host_rx_ready,
    output logic [DW-1:0]         host_tx_data,
    output logic                  host_tx_sof,
    output logic                  host_tx_eof,
    output logic                  host_tx_valid,
    input  logic                  host_tx_ready,
    output logic [NUM_DEV*DW-1:0] dev_tx_data,
    output logic [NUM_DEV-1:0]    dev_tx_sof,
    output logic [NUM_DEV-1:0]    dev_tx_eof,
    output logic [NUM_DEV-1:0]    dev_tx_valid,
    input  logic [NUM_DEV-1:0]    dev_tx_ready,
    input  logic [NUM_DEV*DW-1:0] dev_rx_data,
    input  logic [NUM_DEV-1:0]    dev_rx_sof,
    input  logic [NUM_DEV-1:0]    dev_rx_eof,
    input  logic [NUM_DEV-1:0]    dev_rx_valid,
    output logic [NUM_DEV-1:0]    dev_rx_ready,
    output logic                  bad_port_err
);

    localparam int NSRC = NUM_DEV + 1;

    logic          cq_valid, cq_ready;
    logic [DW-1:0] rs_data;
    logic          rs_sof, rs_eof, rs_valid, rs_ready;
    logic [NSRC-1:0] all_ready;

    assign dev_tx_data = {NUM_DEV{host_rx_data}};
    assign dev_tx_sof  = {NUM_DEV{host_rx_sof}};
    assign dev_tx_eof  = {NUM_DEV{host_rx_eof}};

    pmr_down_steer #(
        .NUM_DEV (NUM_DEV),
        .DW      (DW),
        .PF_LSB  (PF_LSB),
        .PF_W    (PF_W)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (host_rx_data),
        .in_sof    (host_rx_sof),
        .in_eof    (host_rx_eof),
        .in_valid  (host_rx_valid),
        .in_ready  (host_rx_ready),
        .dev_valid (dev_tx_valid),
        .dev_ready (dev_tx_ready),
        .ctl_valid (cq_valid),
        .ctl_ready (cq_ready),
        .bad_err   (bad_port_err)
    );

    pmr_ctrl_ep #(
        .NUM_DEV (NUM_DEV),
        .DW      (DW),
        .PF_LSB  (PF_LSB),
        .PF_W    (PF_W),
        .RA_W    (RA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rq_data  (host_rx_data),
        .rq_sof   (host_rx_sof),
        .rq_eof   (host_rx_eof),
        .rq_valid (cq_valid),
        .rq_ready (cq_ready),
        .err_in   (bad_port_err),
        .rs_data  (rs_data),
        .rs_sof   (rs_sof),
        .rs_eof   (rs_eof),
        .rs_valid (rs_valid),
        .rs_ready (rs_ready)
    );

    pmr_up_arb #(
        .NUM_DEV (NUM_DEV),
        .DW      (DW),
        .PF_LSB  (PF_LSB),
        .PF_W    (PF_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_data  ({rs_data, dev_rx_data}),
        .src_sof   ({rs_sof, dev_rx_sof}),
        .src_eof   ({rs_eof, dev_rx_eof}),
        .src_valid ({rs_valid, dev_rx_valid}),
        .src_ready (all_ready),
        .up_data   (host_tx_data),
        .up_sof    (host_tx_sof),
        .up_eof    (host_tx_eof),
        .up_valid  (host_tx_valid),
        .up_ready  (host_tx_ready)
    );

    assign dev_rx_ready = all_ready[NUM_DEV-1:0];
    assign rs_ready     = all_ready[NUM_DEV];

endmodule

// File: tb/sim_pm_frame_router.sv
module sim_pm_frame_router;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  host_rx_data = '0;
    logic         host_rx_sof = 1'b0, host_rx_eof = 1'b0, host_rx_valid = 1'b0;
    logic         host_rx_ready;
    logic [31:0]  host_tx_data;
    logic         host_tx_sof, host_tx_eof, host_tx_valid;
    logic         host_tx_ready = 1'b1;
    logic [127:0] dev_tx_data;
    logic [3:0]   dev_tx_sof, dev_tx_eof, dev_tx_valid;
    logic [3:0]   dev_tx_ready = '1;
    logic [127:0] dev_rx_data = '0;
    logic [3:0]   dev_rx_sof = '0, dev_rx_eof = '0, dev_rx_valid = '0;
    logic [3:0]   dev_rx_ready;
    logic         bad_port_err;

    pm_frame_router u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    // word = {sof, eof, data}
    logic [33:0] hq[$];
    logic [33:0] dq[4][$];
    logic [33:0] exp_dn[4][$];
    logic [33:0] exp_up[5][$];
    int          ord[$];

    int  nvec = 0, nerr = 0, tag = 1, cur_src = -1;
    bit  sched_err = 0, model_err = 0, stall_dn = 0, stall_up = 0;

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic host_frame(input int port, input int len, input int lo);
        logic [31:0] hdr;
        logic [31:0] val;
        hdr = {20'(tag), 4'(port), 8'(lo)};
        for (int k = 0; k < len; k++) begin
            logic [31:0] w;
            w = (k == 0) ? hdr : {8'h5A, 16'(tag), 8'(k)};
            hq.push_back({k == 0, k == len - 1, w});
            if (port < 4) exp_dn[port].push_back({k == 0, k == len - 1, w});
        end
        if (port == 15) begin
            val = (lo == 0) ? 32'd4 : (lo == 1) ? 32'(sched_err) : 32'd0;
            exp_up[4].push_back({2'b10, hdr});
            exp_up[4].push_back({2'b01, val});
        end else if (port > 3) begin
            sched_err = 1;
        end
        tag++;
    endtask

    task automatic dev_frame(input int d, input int len, input int fld);
        for (int k = 0; k < len; k++) begin
            logic [31:0] w;
            logic [31:0] e;
            w = (k == 0) ? {20'(tag), 4'(fld), 8'(tag)} : {8'hC3, 16'(tag), 8'(k)};
            e = w;
            if (k == 0) e[11:8] = 4'(d);
            dq[d].push_back({k == 0, k == len - 1, w});
            exp_up[d].push_back({k == 0, k == len - 1, e});
        end
        tag++;
    endtask

    function automatic bit all_empty();
        bit e;
        e = (hq.size() == 0) && (cur_src < 0) && (exp_up[4].size() == 0);
        for (int d = 0; d < 4; d++)
            e = e && dq[d].size() == 0 && exp_dn[d].size() == 0 && exp_up[d].size() == 0;
        return e;
    endfunction

    task automatic drain(input string r);
        int n;
        n = 0;
        while (!all_empty() && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(r, 64'(all_empty()), 64'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic observe();
        logic [33:0] w;
        logic [3:0]  f;
        bit          nerr_next;
        nerr_next = model_err;
        if (host_rx_valid && host_rx_ready) begin
            w = hq.pop_front();
            f = w[11:8];
            if (w[33] && f > 3 && f != 15) nerr_next = 1;
        end
        chk("R4 flag", 64'(bad_port_err), 64'(model_err));
        model_err = nerr_next;
        for (int d = 0; d < 4; d++) begin
            if (dev_tx_valid[d] && dev_tx_ready[d]) begin
                if (exp_dn[d].size() == 0)
                    chk("R2 unexpected", {30'd0, dev_tx_sof[d], dev_tx_eof[d], dev_tx_data[d*32 +: 32]}, 64'd0);
                else
                    chk("R2", {30'd0, dev_tx_sof[d], dev_tx_eof[d], dev_tx_data[d*32 +: 32]},
                        64'(exp_dn[d].pop_front()));
            end
            if (dev_rx_valid[d] && dev_rx_ready[d]) dq[d].delete(0);
        end
        if (host_tx_valid && host_tx_ready) begin
            w = {host_tx_sof, host_tx_eof, host_tx_data};
            if (cur_src < 0) begin
                f = host_tx_data[11:8];
                if (!host_tx_sof) chk("R6 start", 64'(host_tx_sof), 64'd1);
                else if (f > 3 && f != 15) chk("R5 field", 64'(f), 64'd15);
                else begin
                    cur_src = (f == 15) ? 4 : int'(f);
                    ord.push_back(cur_src);
                end
            end
            if (cur_src >= 0) begin
                if (exp_up[cur_src].size() == 0) chk("R6 extra", 64'(w), 64'd0);
                else chk(host_tx_sof ? (cur_src == 4 ? "R3" : "R5") : "R6", 64'(w),
                         64'(exp_up[cur_src].pop_front()));
                if (host_tx_eof) cur_src = -1;
            end
        end
    endtask

    // drive at negedge, sample one time unit before the rising edge
    always begin
        @(negedge clk);
        host_rx_valid = hq.size() > 0;
        {host_rx_sof, host_rx_eof, host_rx_data} = (hq.size() > 0) ? hq[0] : 34'd0;
        for (int d = 0; d < 4; d++) begin
            dev_rx_valid[d] = dq[d].size() > 0;
            {dev_rx_sof[d], dev_rx_eof[d], dev_rx_data[d*32 +: 32]} = (dq[d].size() > 0) ? dq[d][0] : 34'd0;
            dev_tx_ready[d] = stall_dn ? (($urandom % 3) != 0) : 1'b1;
        end
        host_tx_ready = stall_up ? (($urandom % 2) != 0) : 1'b1;
        #(CLK_P/2 - 1);
        if (rst_n) observe();
    end

    task automatic chk_order(input int exp[]);
        chk("R7 count", 64'(ord.size()), 64'(exp.size()));
        for (int k = 0; k < exp.size() && k < ord.size(); k++)
            chk("R7", 64'(ord[k]), 64'(exp[k]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_P/2 - 1);
        chk("R1 host_tx_valid", 64'(host_tx_valid), 64'd0);
        chk("R1 dev_tx_valid", 64'(dev_tx_valid), 64'd0);
        chk("R1 err", 64'(bad_port_err), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: first arbitration after reset serves device 0
        ord.delete();
        dev_frame(2, 2, 9);
        dev_frame(0, 2, 9);
        drain("R7 drain");
        chk_order('{0, 2});

        // R2, R8: steering with throttled devices, single-word and long frames
        stall_dn = 1;
        host_frame(0, 4, 0); host_frame(1, 1, 0); host_frame(2, 6, 0);
        host_frame(3, 2, 0); host_frame(0, 1, 0); host_frame(3, 5, 0);
        drain("R2 drain");

        // R3 before any error, then R4, then R3 again
        host_frame(15, 1, 1);
        host_frame(15, 3, 0);
        host_frame(15, 1, 7);
        host_frame(7, 3, 0);
        host_frame(1, 2, 0);
        host_frame(14, 1, 0);
        host_frame(15, 1, 1);
        host_frame(4, 2, 0);
        host_frame(2, 1, 0);
        drain("R4 drain");

        // R5, R6, R8: throttled upstream with concurrent device frames
        stall_up = 1;
        for (int d = 0; d < 4; d++) begin
            dev_frame(d, 3 + d, 15 - d);
            dev_frame(d, 1, d);
        end
        drain("R6 drain");

        // R7: known last grant (3), all devices pending twice
        stall_up = 0; stall_dn = 0;
        dev_frame(3, 1, 0);
        drain("R7 drain");
        ord.delete();
        for (int d = 0; d < 4; d++) begin
            dev_frame(d, 3, 0);
            dev_frame(d, 2, 0);
        end
        drain("R7 drain");
        chk_order('{0, 1, 2, 3, 0, 1, 2, 3});

        // R7: after grant to 1, device 2 beats device 0
        dev_frame(1, 2, 0);
        drain("R7 drain");
        ord.delete();
        dev_frame(0, 2, 0);
        dev_frame(2, 2, 0);
        drain("R7 drain");
        chk_order('{2, 0});

        // control responses contend with device frames while steering runs
        stall_up = 1; stall_dn = 1;
        for (int d = 0; d < 4; d++) dev_frame(d, 4, 6);
        host_frame(15, 1, 0);
        host_frame(2, 3, 0);
        host_frame(15, 2, 1);
        host_frame(0, 2, 0);
        host_frame(15, 1, 9);
        for (int d = 0; d < 4; d++) dev_frame(d, 2, 15);
        drain("R3 drain");

        chk("R4 final", 64'(bad_port_err), 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        nerr++;
        $display("FAIL R6 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule